// File: doc/BRIEF.md
# Five-Tap Spatial Derivative Unit

This block produces the horizontal and vertical intensity gradients at the centre of a 5x5 pixel neighbourhood. An external window buffer supplies the five pixels of the centre row and the five pixels of the centre column. A one-cycle `start` strobe captures both lines. Each line is combined with the coefficients 1, -8, 0, 8, -1 (tap 0 to tap 4). The signed sum is divided by 12 and the quotient is truncated toward zero.

The block has no general multiplier. Weights of magnitude 8 come from a three-bit left shift, and weights of magnitude 1 come from plain addition or subtraction. The centre tap is never read. Each axis has a small sequential divider that retires two quotient bits per clock. Both axes run side by side and share one controller, so a single `done` pulse reports both results. While a computation is in flight, further `start` strobes are ignored.

Top module: `grad5_deriv`

## Requirements
- R1: While reset is asserted and after it is released, `dx`, `dy` and `done` read 0 until the first result is produced.
- R2: Tap k of `row_taps` occupies bits [k*PIX_W +: PIX_W] as an unsigned pixel. `dx` equals (t0 - 8*t1 + 8*t3 - t4) / 12 of the row taps captured at the accepted start.
- R3: `dy` is formed the same way as in R2 from `col_taps`, which uses the same tap packing.
- R4: Tap 2 of either line has no effect on the result.
- R5: The quotient is truncated toward zero for negative sums as well as positive ones. A sum of -13 gives -1 and a sum of -11 gives 0.
- R6: If a start is accepted at clock edge E, `done` is high for exactly one cycle, after edge E+5. `dx` and `dy` take their new values at that same edge.
- R7: A start is accepted only when the unit is idle. A start at edges E+1 through E+5 is ignored. A start at edge E+6 is accepted, which gives one result every 6 cycles.
- R8: `dx` and `dy` hold their values between done pulses. Changes on the taps after the accepted start do not alter the pending result.
- R9: The full input range is handled without overflow. The largest sum, ±2295 for 8-bit pixels, yields ±191 in the 9-bit signed outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Capture the taps and begin a computation (accepted when idle) |
| row_taps | input | 5*PIX_W | Centre-row pixels, tap k at bits [k*PIX_W +: PIX_W] |
| col_taps | input | 5*PIX_W | Centre-column pixels, same packing |
| dx | output | PIX_W+1 | Signed horizontal derivative |
| dy | output | PIX_W+1 | Signed vertical derivative |
| done | output | 1 | One-cycle pulse when `dx` and `dy` are updated |

## Verification
The embedded assertions watch the controller and divider on every cycle. They check that `done` is a single-cycle pulse that always follows the final stage, and that the step counter advances by one per divide cycle. They also check that the partial remainder stays below the divisor, that the output sign follows the captured sign, and that the outputs stay put outside a finish. Only the bench's scenarios can show the arithmetic itself. These cover the tap order and packing, the ignored centre tap, truncation of negative sums, the extreme values, and the rejection of starts while busy. For these, a behavioural model predicts `done`, `dx` and `dy` on every clock.

// File: rtl/grad5_pkg.sv
package grad5_pkg;

  localparam int NTAPS   = 5;
  localparam int CENTRE  = 2;
  localparam int DIVISOR = 12;
  localparam int SHIFT8  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIX  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/grad5_tapsum.sv
module grad5_tapsum
  import grad5_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int SUM_W = PIX_W + 5
) (
  input  logic [NTAPS*PIX_W-1:0] taps,
  output logic signed [SUM_W-1:0] sum
);

  logic signed [SUM_W-1:0] far_lo;
  logic signed [SUM_W-1:0] near_lo;
  logic signed [SUM_W-1:0] near_hi;
  logic signed [SUM_W-1:0] far_hi;
  logic signed [SUM_W-1:0] outer_diff;
  logic signed [SUM_W-1:0] inner_diff;
  logic                    unused_centre;

  assign far_lo  = signed'({{(SUM_W-PIX_W){1'b0}}, taps[0*PIX_W +: PIX_W]});
  assign near_lo = signed'({{(SUM_W-PIX_W){1'b0}}, taps[1*PIX_W +: PIX_W]});
  assign near_hi = signed'({{(SUM_W-PIX_W){1'b0}}, taps[3*PIX_W +: PIX_W]});
  assign far_hi  = signed'({{(SUM_W-PIX_W){1'b0}}, taps[4*PIX_W +: PIX_W]});

  // centre weight is zero: the tap is deliberately left out of the sum
  assign unused_centre = ^taps[CENTRE*PIX_W +: PIX_W];

  // weights +/-1 by add/subtract, weights +/-8 by a left shift
  always_comb begin
    outer_diff = far_lo - far_hi;
    inner_diff = near_hi - near_lo;
    sum        = outer_diff + (inner_diff <<< SHIFT8);
  end

endmodule

// File: rtl/grad5_div12.sv
module grad5_div12
  import grad5_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BITS_PER_STEP = 2,
  localparam int SUM_W = PIX_W + 5,
  localparam int MAG_W = SUM_W - 1,
  localparam int QB    = PIX_W,
  localparam int REM_W = MAG_W - QB,
  localparam int OUT_W = PIX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    finish,
  input  logic signed [SUM_W-1:0] sum,
  output logic signed [OUT_W-1:0] res
);

  logic                    neg_q, neg_d;
  logic [REM_W-1:0]        rem_q, rem_d;
  logic [QB-1:0]           shr_q, shr_d;
  logic signed [OUT_W-1:0] res_q, res_d;

  logic signed [SUM_W-1:0] abs_full;
  logic [MAG_W-1:0]        mag;
  logic [REM_W-1:0]        rem_step;
  logic [QB-1:0]           shr_step;
  logic signed [OUT_W-1:0] q_pos;

  // magnitude of the captured sum
  always_comb begin
    abs_full = sum[SUM_W-1] ? -sum : sum;
    mag      = MAG_W'(abs_full);
  end

  // restoring division, BITS_PER_STEP quotient bits per cycle
  always_comb begin
    logic [REM_W-1:0] r;
    logic [QB-1:0]    s;
    logic [REM_W:0]   t;
    r = rem_q;
    s = shr_q;
    for (int i = 0; i < BITS_PER_STEP; i++) begin
      t = {r, s[QB-1]};
      if (t >= (REM_W+1)'(DIVISOR)) begin
        r = REM_W'(t - (REM_W+1)'(DIVISOR));
        s = {s[QB-2:0], 1'b1};
      end else begin
        r = REM_W'(t);
        s = {s[QB-2:0], 1'b0};
      end
    end
    rem_step = r;
    shr_step = s;
  end

  assign q_pos = signed'({1'b0, shr_q});

  // next-state
  always_comb begin
    neg_d = neg_q;
    rem_d = rem_q;
    shr_d = shr_q;
    res_d = res_q;
    if (load) begin
      neg_d = sum[SUM_W-1];
      rem_d = mag[MAG_W-1:QB];
      shr_d = mag[QB-1:0];
    end else if (step) begin
      rem_d = rem_step;
      shr_d = shr_step;
    end
    if (finish) begin
      res_d = neg_q ? -q_pos : q_pos;
    end
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      rem_q <= '0;
      shr_q <= '0;
      res_q <= '0;
    end else begin
      if (load) begin
        neg_q <= neg_d;
      end
      if (load || step) begin
        rem_q <= rem_d;
        shr_q <= shr_d;
      end
      if (finish) begin
        res_q <= res_d;
      end
    end
  end

  assign res = res_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rem_q) < DIVISOR);  // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(res_q));  // R8
  AST_RESULT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && shr_q != '0) |=> (res_q[OUT_W-1] == $past(neg_q)));  // R5

endmodule

// File: rtl/grad5_seq.sv
module grad5_seq
  import grad5_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic done
);

  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  seq_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_DIV;
          cnt_d   = '0;
        end
      end
      ST_DIV: begin
        step = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIX;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIX: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R6
  AST_FIX_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX) |=> done_q);  // R6
  AST_DONE_FROM_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == ST_FIX));  // R6
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV && cnt_q != LAST) |=>
      (state_q == ST_DIV && cnt_q == $past(cnt_q) + 1'b1));  // R7

endmodule

// File: rtl/grad5_deriv.sv
module grad5_deriv
  import grad5_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int SUM_W = PIX_W + 5,
  localparam int OUT_W = PIX_W + 1,
  localparam int BPS   = 2,
  localparam int STEPS = PIX_W / BPS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NTAPS*PIX_W-1:0]    row_taps,
  input  logic [NTAPS*PIX_W-1:0]    col_taps,
  output logic signed [OUT_W-1:0]   dx,
  output logic signed [OUT_W-1:0]   dy,
  output logic                      done
);

  localparam int NAXES = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic load, step, finish;

  grad5_seq #(.STEPS(STEPS)) i_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .done   (done)
  );

  logic [NAXES-1:0][NTAPS*PIX_W-1:0] ax_taps;
  logic [NAXES-1:0][OUT_W-1:0]       ax_res;

  assign ax_taps[0] = row_taps;
  assign ax_taps[1] = col_taps;

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    logic signed [SUM_W-1:0] sum;
    logic signed [OUT_W-1:0] res;

    grad5_tapsum #(.PIX_W(PIX_W)) i_tapsum (
      .taps (ax_taps[a]),
      .sum  (sum)
    );

    grad5_div12 #(.PIX_W(PIX_W), .BITS_PER_STEP(BPS)) i_div (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .load   (load),
      .step   (step),
      .finish (finish),
      .sum    (sum),
      .res    (res)
    );

    assign ax_res[a] = res;
  end

  assign dx = signed'(ax_res[0]);
  assign dy = signed'(ax_res[1]);

  AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done |=> (done || ($stable(dx) && $stable(dy))));  // R8

endmodule

// File: tb/test_grad5_deriv.sv
`timescale 1ns/1ps
module test_grad5_deriv;

  localparam int PW = 8;
  localparam int OW = PW + 1;
  localparam int TW = 5 * PW;

  logic                 clk;
  logic                 rst_n;
  logic                 start;
  logic [TW-1:0]        row_taps;
  logic [TW-1:0]        col_taps;
  logic signed [OW-1:0] dx;
  logic signed [OW-1:0] dy;
  logic                 done;

  int    n_checks;
  int    n_fail;
  int    cyc;
  string cur_req;
  bit    chk_en;

  grad5_deriv #(.PIX_W(PW)) i_grad5_deriv (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .row_taps (row_taps),
    .col_taps (col_taps),
    .dx       (dx),
    .dy       (dy),
    .done     (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int deriv_ref(logic [TW-1:0] t);
    int p [5];
    int s;
    for (int k = 0; k < 5; k++) p[k] = int'(t[k*PW +: PW]);
    s = p[0] - 8 * p[1] + 8 * p[3] - p[4];
    return s / 12;
  endfunction

  function automatic logic [TW-1:0] pack(int a, int b, int c, int d, int e);
    return {e[PW-1:0], d[PW-1:0], c[PW-1:0], b[PW-1:0], a[PW-1:0]};
  endfunction

  task automatic check(string req, int act, int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // behavioural reference: countdown after an accepted start
  int m_cnt, m_px, m_py, m_ex, m_ey;
  bit m_done;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ex = 0; m_ey = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_cnt == 0) begin
        if (start) begin
          m_px = deriv_ref(row_taps);
          m_py = deriv_ref(col_taps);
          m_cnt = 5;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          m_ex = m_px;
          m_ey = m_py;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      check("R6 done timing", int'(done), int'(m_done));
      if (m_done) begin
        check({cur_req, " dx"}, int'(dx), m_ex);
        check({cur_req, " dy"}, int'(dy), m_ey);
      end else begin
        check("R8 dx hold", int'(dx), m_ex);
        check("R8 dy hold", int'(dy), m_ey);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic op(logic [TW-1:0] h, logic [TW-1:0] v);
    @(negedge clk);
    row_taps = h;
    col_taps = v;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0; chk_en = 0;
    cur_req  = "R2";
    start    = 1'b0;
    row_taps = '0;
    col_taps = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 dx reset", int'(dx), 0);
    check("R1 dy reset", int'(dy), 0);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 dx after release", int'(dx), 0);
    check("R1 done after release", int'(done), 0);
    chk_en = 1;

    // R2 / R3: distinct patterns on each axis
    cur_req = "R2";
    op(pack(10, 20, 0, 90, 5), pack(0, 0, 0, 0, 0));          // (10-160+720-5)/12 = 47
    op(pack(200, 3, 7, 1, 0), pack(1, 1, 1, 1, 1));
    cur_req = "R3";
    op(pack(0, 0, 0, 0, 0), pack(3, 100, 50, 40, 9));          // negative slope
    op(pack(5, 5, 5, 5, 5), pack(0, 0, 255, 12, 0));

    // R4: centre tap varies, outer taps fixed
    cur_req = "R4";
    op(pack(11, 22, 0, 33, 44), pack(44, 33, 0, 22, 11));
    op(pack(11, 22, 255, 33, 44), pack(44, 33, 255, 22, 11));
    op(pack(11, 22, 128, 33, 44), pack(44, 33, 77, 22, 11));

    // R5: truncation toward zero near the divisor
    cur_req = "R5";
    op(pack(0, 0, 0, 0, 13), pack(0, 0, 0, 0, 11));            // -13 -> -1, -11 -> 0
    op(pack(13, 0, 0, 0, 0), pack(0, 0, 0, 0, 12));            // 13 -> 1, -12 -> -1
    op(pack(0, 0, 0, 0, 23), pack(0, 0, 0, 0, 25));            // -1, -2

    // R9: extremes of the range
    cur_req = "R9";
    op(pack(255, 0, 0, 255, 0), pack(0, 255, 0, 0, 255));      // 191 and -191
    op(pack(255, 255, 255, 255, 255), pack(0, 0, 0, 0, 0));

    // R7: start held high, taps change each cycle
    cur_req = "R7";
    @(negedge clk);
    start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      row_taps = pack(i * 5, 255 - i, i, i * 3, 7);
      col_taps = pack(i, i * 6, 0, 200 - i, i * 2);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (8) @(negedge clk);

    // R8: taps change while a result is pending
    cur_req = "R8";
    @(negedge clk);
    row_taps = pack(40, 4, 0, 60, 2);
    col_taps = pack(2, 60, 0, 4, 40);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      row_taps = pack(255, 255, 255, 0, 255);
      col_taps = pack(0, 0, 0, 255, 0);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);

    // R2 and R3 under random traffic
    cur_req = "R2 R3 random";
    for (int i = 0; i < 600; i++) begin
      start    = 1'($urandom_range(0, 1));
      row_taps = TW'({$urandom, $urandom});
      col_taps = TW'({$urandom, $urandom});
      @(negedge clk);
    end
    start = 1'b0;
    repeat (10) @(negedge clk);

    finish_run();
  end

endmodule